// File: doc/BRIEF.md
# Exception entry sequencer

This block takes a processor core from the moment a fault or interrupt is detected to the moment the first handler instruction fetch is launched. When a request is accepted it keeps a copy of the status word. It then publishes an updated status word in supervisor state with tracing off. For interrupts it also clears the master-state bit and raises the priority mask to the request level.

Next it determines a vector number. A fault takes its vector from an internal table indexed by fault type. An interrupt takes its vector from an acknowledge read whose address carries the request level. The block then pushes a two-word frame below the single system stack pointer, after rounding that pointer down to a word boundary. It reads the handler address from the vector table and strobes the fetch request.

All memory traffic goes through one simple request/acknowledge port. The caller supplies the current program counter, status word, stack pointer and vector base with the request. It receives the new status word, the new stack pointer and the handler address as single-cycle strobed outputs.

Top module: `exc_entry_seq`

## Requirements
- R1: A `req_valid` seen while idle is accepted, and `busy` rises in the following cycle. `busy` stays high up to and including the cycle in which `fetch_go` is high, and it is low in the cycle after.
- R2: In the first busy cycle, `sr_we` is high for exactly one cycle. `sr_out` equals the captured `sr_in` with bit 13 (supervisor) set and bit 15 (trace) cleared; for a fault every other bit is unchanged.
- R3: For an interrupt request, `sr_out` additionally has bit 12 (master state) cleared and bits [10:8] (priority mask) equal to `req_level`.
- R4: For a fault, the vector number is `FAULT_VEC_FIRST + req_type`.
- R5: For an interrupt, the first bus access is a read with `bus_iack` high. Its address is `IACK_BASE` with `req_level` placed in bits [4:2], and bits [7:0] of the returned data become the vector number.
- R6: The frame is written as two word writes, in this order. First the saved program counter goes to `(sp_in & ~3) - 4`. Then the status word goes to `(sp_in & ~3) - 8`: bits [31:30] are 2'b01, bits [29:28] hold `sp_in[1:0]` (the bytes skipped), bits [27:24] are zero, bits [23:16] hold the vector and bits [15:0] hold the saved status word.
- R7: After the second frame write is acknowledged, `sp_we` pulses for one cycle with `sp_out = (sp_in & ~3) - 8`.
- R8: The last bus access is a read of `vbr_in + 4 * vector`. `fetch_go` then pulses for one cycle, with `fetch_addr` equal to the data returned by that read.
- R9: Bus accesses occur strictly in the order vector acknowledge (interrupt only), program counter write, status word write, handler read, with no other accesses.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` stay unchanged.
- R11: A `req_valid` that arrives while `busy` is high has no effect: no further `sr_we` pulse occurs and the access sequence in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request strobe |
| req_is_irq | input | 1 | Request is an interrupt (1) or a fault (0) |
| req_type | input | TYPE_W | Fault type index |
| req_level | input | 3 | Interrupt request level |
| req_pc | input | 32 | Program counter to save |
| sr_in | input | 16 | Current status word |
| sp_in | input | 32 | Current system stack pointer |
| vbr_in | input | 32 | Vector table base address |
| busy | output | 1 | Sequence in progress |
| sr_out | output | 16 | Updated status word |
| sr_we | output | 1 | Strobe for `sr_out` |
| sp_out | output | 32 | Updated stack pointer |
| sp_we | output | 1 | Strobe for `sp_out` |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_iack | output | 1 | Access is in the acknowledge address space |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completes this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| fetch_go | output | 1 | Handler fetch strobe |
| fetch_addr | output | 32 | Handler address |

## Verification
The bench builds the block with its defaults: `TYPE_W = 3`, `FAULT_VEC_FIRST = 2` and `IACK_BASE = 32'hFFFF_FFE0`. With these values the lowest and highest fault types (vectors 2 and 9) and interrupt levels from 1 up to 7 can be covered in a handful of runs. Stack pointers with each of the four low-bit residues exercise every skip count in the frame word. The bus model acknowledges after zero to three wait cycles, which tests that requests are held steady and that back-to-back accesses on an immediate acknowledge are handled.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int WORD_W      = 32;
    localparam int SR_W        = 16;
    localparam int VEC_W       = 8;
    localparam int LVL_W       = 3;
    localparam int SR_T_BIT    = 15;
    localparam int SR_S_BIT    = 13;
    localparam int SR_M_BIT    = 12;
    localparam int SR_MASK_LSB = 8;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_IACK     = 3'd1,
        ST_PUSH_PC  = 3'd2,
        ST_PUSH_FMT = 3'd3,
        ST_HREAD    = 3'd4,
        ST_FETCH    = 3'd5
    } exc_state_e;

    // status-word frame entry: format tag, skip count, vector, saved status
    function automatic logic [WORD_W-1:0] frame_status_word(
        input logic [1:0]       skip,
        input logic [VEC_W-1:0] vec,
        input logic [SR_W-1:0]  sr
    );
        return {2'b01, skip, 4'b0000, vec, sr};
    endfunction
endpackage

// File: rtl/exc_sr_shaper.sv
module exc_sr_shaper
    import exc_pkg::*;
(
    input  logic [SR_W-1:0]  sr_cur,
    input  logic             is_irq,
    input  logic [LVL_W-1:0] level,
    output logic [SR_W-1:0]  sr_new
);
    always_comb begin
        sr_new = sr_cur;
        sr_new[SR_S_BIT] = 1'b1;
        sr_new[SR_T_BIT] = 1'b0;
        if (is_irq) begin
            sr_new[SR_M_BIT] = 1'b0;
            sr_new[SR_MASK_LSB +: LVL_W] = level;
        end
    end
endmodule

// File: rtl/exc_fault_vec.sv
module exc_fault_vec
    import exc_pkg::*;
#(
    parameter int TYPE_W          = 3,
    parameter int FAULT_VEC_FIRST = 2
) (
    input  logic [TYPE_W-1:0] fault_type,
    output logic [VEC_W-1:0]  vec
);
    localparam int NUM_TYPES = 1 << TYPE_W;

    logic [VEC_W-1:0] tbl [NUM_TYPES];

    for (genvar i = 0; i < NUM_TYPES; i++) begin : g_entry
        assign tbl[i] = VEC_W'(FAULT_VEC_FIRST + i);
    end

    assign vec = tbl[fault_type];
endmodule

// File: rtl/exc_frame_calc.sv
module exc_frame_calc
    import exc_pkg::*;
(
    input  logic [WORD_W-1:0] sp_cur,
    output logic [WORD_W-1:0] pc_slot,
    output logic [WORD_W-1:0] st_slot,
    output logic [1:0]        skip
);
    logic [WORD_W-1:0] sp_aligned;

    assign sp_aligned = {sp_cur[WORD_W-1:2], 2'b00};
    assign pc_slot    = sp_aligned - WORD_W'(4);
    assign st_slot    = sp_aligned - WORD_W'(8);
    assign skip       = sp_cur[1:0];
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int          TYPE_W          = 3,
    parameter int          FAULT_VEC_FIRST = 2,
    parameter logic [31:0] IACK_BASE       = 32'hFFFF_FFE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_irq,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [2:0]        req_level,
    input  logic [31:0]       req_pc,
    input  logic [15:0]       sr_in,
    input  logic [31:0]       sp_in,
    input  logic [31:0]       vbr_in,
    output logic              busy,
    output logic [15:0]       sr_out,
    output logic              sr_we,
    output logic [31:0]       sp_out,
    output logic              sp_we,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_iack,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata,
    output logic              fetch_go,
    output logic [31:0]       fetch_addr
);
    typedef struct packed {
        exc_state_e        state;
        logic              busy;
        logic [WORD_W-1:0] pc;
        logic [SR_W-1:0]   sr_saved;
        logic [WORD_W-1:0] pc_slot;
        logic [WORD_W-1:0] st_slot;
        logic [1:0]        skip;
        logic [WORD_W-1:0] vbr;
        logic [VEC_W-1:0]  vector;
        logic              bus_req;
        logic              bus_we;
        logic              bus_iack;
        logic [WORD_W-1:0] bus_addr;
        logic [WORD_W-1:0] bus_wdata;
        logic [SR_W-1:0]   sr_out;
        logic              sr_we;
        logic [WORD_W-1:0] sp_out;
        logic              sp_we;
        logic              fetch_go;
        logic [WORD_W-1:0] fetch_addr;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [SR_W-1:0]   sr_new;
    logic [VEC_W-1:0]  fault_vec;
    logic [WORD_W-1:0] pc_slot_c;
    logic [WORD_W-1:0] st_slot_c;
    logic [1:0]        skip_c;
    logic [WORD_W-1:0] iack_addr;

    exc_sr_shaper u_sr (
        .sr_cur (sr_in),
        .is_irq (req_is_irq),
        .level  (req_level),
        .sr_new (sr_new)
    );

    exc_fault_vec #(
        .TYPE_W          (TYPE_W),
        .FAULT_VEC_FIRST (FAULT_VEC_FIRST)
    ) u_vec (
        .fault_type (req_type),
        .vec        (fault_vec)
    );

    exc_frame_calc u_frame (
        .sp_cur  (sp_in),
        .pc_slot (pc_slot_c),
        .st_slot (st_slot_c),
        .skip    (skip_c)
    );

    assign iack_addr = {IACK_BASE[31:5], req_level, IACK_BASE[1:0]};

    always_comb begin
        r_d          = r_q;
        r_d.sr_we    = 1'b0;
        r_d.sp_we    = 1'b0;
        r_d.fetch_go = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.busy     = 1'b1;
                    r_d.pc       = req_pc;
                    r_d.sr_saved = sr_in;
                    r_d.pc_slot  = pc_slot_c;
                    r_d.st_slot  = st_slot_c;
                    r_d.skip     = skip_c;
                    r_d.vbr      = vbr_in;
                    r_d.sr_out   = sr_new;
                    r_d.sr_we    = 1'b1;
                    r_d.bus_req  = 1'b1;
                    if (req_is_irq) begin
                        r_d.state     = ST_IACK;
                        r_d.bus_we    = 1'b0;
                        r_d.bus_iack  = 1'b1;
                        r_d.bus_addr  = iack_addr;
                        r_d.bus_wdata = '0;
                    end else begin
                        r_d.state     = ST_PUSH_PC;
                        r_d.vector    = fault_vec;
                        r_d.bus_we    = 1'b1;
                        r_d.bus_iack  = 1'b0;
                        r_d.bus_addr  = pc_slot_c;
                        r_d.bus_wdata = req_pc;
                    end
                end
            end
            ST_IACK: begin
                if (bus_ack) begin
                    r_d.state     = ST_PUSH_PC;
                    r_d.vector    = bus_rdata[VEC_W-1:0];
                    r_d.bus_we    = 1'b1;
                    r_d.bus_iack  = 1'b0;
                    r_d.bus_addr  = r_q.pc_slot;
                    r_d.bus_wdata = r_q.pc;
                end
            end
            ST_PUSH_PC: begin
                if (bus_ack) begin
                    r_d.state     = ST_PUSH_FMT;
                    r_d.bus_addr  = r_q.st_slot;
                    r_d.bus_wdata = frame_status_word(r_q.skip, r_q.vector, r_q.sr_saved);
                end
            end
            ST_PUSH_FMT: begin
                if (bus_ack) begin
                    r_d.state     = ST_HREAD;
                    r_d.bus_we    = 1'b0;
                    r_d.bus_addr  = r_q.vbr + {{(WORD_W-VEC_W-2){1'b0}}, r_q.vector, 2'b00};
                    r_d.bus_wdata = '0;
                    r_d.sp_out    = r_q.st_slot;
                    r_d.sp_we     = 1'b1;
                end
            end
            ST_HREAD: begin
                if (bus_ack) begin
                    r_d.state      = ST_FETCH;
                    r_d.bus_req    = 1'b0;
                    r_d.fetch_go   = 1'b1;
                    r_d.fetch_addr = bus_rdata;
                end
            end
            ST_FETCH: begin
                r_d.state = ST_IDLE;
                r_d.busy  = 1'b0;
            end
            default: begin
                r_d.state   = ST_IDLE;
                r_d.busy    = 1'b0;
                r_d.bus_req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy       = r_q.busy;
    assign sr_out     = r_q.sr_out;
    assign sr_we      = r_q.sr_we;
    assign sp_out     = r_q.sp_out;
    assign sp_we      = r_q.sp_we;
    assign bus_req    = r_q.bus_req;
    assign bus_we     = r_q.bus_we;
    assign bus_iack   = r_q.bus_iack;
    assign bus_addr   = r_q.bus_addr;
    assign bus_wdata  = r_q.bus_wdata;
    assign fetch_go   = r_q.fetch_go;
    assign fetch_addr = r_q.fetch_addr;

    assert_fetch_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |-> busy);

    assert_sr_super_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> (sr_out[SR_S_BIT] && !sr_out[SR_T_BIT]));

    assert_iack_is_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_iack) |-> !bus_we);

    assert_sp_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> (sp_out[1:0] == 2'b00));

    assert_fetch_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |-> ($past(bus_ack) && !bus_req));

    assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_wdata)));

    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !sr_we);
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TYPE_W     = 3;

    typedef struct packed {
        logic        we;
        logic        iack;
        logic [31:0] addr;
        logic [31:0] data;
    } bus_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_is_irq = 1'b0;
    logic [TYPE_W-1:0] req_type = '0;
    logic [2:0]        req_level = '0;
    logic [31:0]       req_pc = '0;
    logic [15:0]       sr_in = '0;
    logic [31:0]       sp_in = '0;
    logic [31:0]       vbr_in = '0;
    logic              busy, sr_we, sp_we, bus_req, bus_we, bus_iack, fetch_go;
    logic [15:0]       sr_out;
    logic [31:0]       sp_out, bus_addr, bus_wdata, fetch_addr;
    logic              bus_ack = 1'b0;
    logic [31:0]       bus_rdata = '0;

    int total = 0;
    int bad = 0;
    int slave_lat = 0;
    logic [7:0] iack_vec = 8'h40;
    int sr_cnt = 0;
    int sp_cnt = 0;
    logic [31:0] sp_seen = '0;
    bus_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq #(.TYPE_W(TYPE_W)) u_dut (
        .clk, .rst_n, .req_valid, .req_is_irq, .req_type, .req_level, .req_pc,
        .sr_in, .sp_in, .vbr_in, .busy, .sr_out, .sr_we, .sp_out, .sp_we,
        .bus_req, .bus_we, .bus_iack, .bus_addr, .bus_wdata, .bus_ack, .bus_rdata,
        .fetch_go, .fetch_addr
    );

    function automatic logic [31:0] handler_of(input logic [31:0] a);
        return {8'h40, a[23:2], 2'b00};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // bus slave and scoreboard monitor
    initial begin : slave
        int cnt = 0;
        logic [31:0] first_addr = '0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
                cnt = 0;
            end else if (bus_req) begin
                if (cnt == 0) first_addr = bus_addr;
                if (cnt >= slave_lat) begin
                    bus_item_t e;
                    chk(bus_addr == first_addr, "R10 addr held", bus_addr, first_addr);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R9 unexpected access", bus_addr, 32'h0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(bus_addr == e.addr, "R9 access address", bus_addr, e.addr);
                        chk(bus_we == e.we, "R9 access direction", 32'(bus_we), 32'(e.we));
                        chk(bus_iack == e.iack, "R5 acknowledge space", 32'(bus_iack), 32'(e.iack));
                        if (e.we)
                            chk(bus_wdata == e.data, "R6 frame data", bus_wdata, e.data);
                    end
                    bus_rdata = bus_iack ? {24'h0, iack_vec} : handler_of(bus_addr);
                    bus_ack = 1'b1;
                end else begin
                    cnt++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (sr_we) sr_cnt++;
        if (sp_we) begin
            sp_cnt++;
            sp_seen = sp_out;
        end
    end

    task automatic run_exc(input logic irq, input logic [TYPE_W-1:0] ftype,
                           input logic [2:0] lvl, input logic [31:0] pc,
                           input logic [15:0] sr, input logic [31:0] sp,
                           input logic [31:0] vbr, input logic [7:0] ivec, input int lat);
        logic [31:0] al, exp_sp, haddr;
        logic [15:0] exp_sr;
        logic [7:0]  vec;
        bit          seen;
        al = {sp[31:2], 2'b00};
        exp_sp = al - 32'd8;
        exp_sr = sr;
        exp_sr[13] = 1'b1;
        exp_sr[15] = 1'b0;
        if (irq) begin
            exp_sr[12] = 1'b0;
            exp_sr[10:8] = lvl;
            vec = ivec;                     // R5 vector from acknowledge data
            exp_q.push_back('{1'b0, 1'b1, {27'h7FFFFFF, lvl, 2'b00}, 32'h0});
        end else begin
            vec = 8'(2 + int'(ftype));      // R4 fault vector
        end
        haddr = vbr + {22'h0, vec, 2'b00};
        exp_q.push_back('{1'b1, 1'b0, al - 32'd4, pc});                                // R6
        exp_q.push_back('{1'b1, 1'b0, exp_sp, {2'b01, sp[1:0], 4'h0, vec, sr}});      // R6
        exp_q.push_back('{1'b0, 1'b0, haddr, 32'h0});                                 // R8
        slave_lat = lat;
        iack_vec = ivec;
        sr_cnt = 0;
        sp_cnt = 0;

        @(negedge clk);
        req_valid = 1'b1; req_is_irq = irq; req_type = ftype; req_level = lvl;
        req_pc = pc; sr_in = sr; sp_in = sp; vbr_in = vbr;
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy after accept", 32'(busy), 32'h1);
        chk(sr_we == 1'b1, "R2 status strobe", 32'(sr_we), 32'h1);
        chk(sr_out == exp_sr, irq ? "R3 interrupt status" : "R2 fault status",
            32'(sr_out), 32'(exp_sr));
        // R11: keep a conflicting request asserted during the sequence
        req_is_irq = ~irq; req_type = ~ftype; req_level = ~lvl; sp_in = sp + 32'h100;
        req_pc = ~pc; sr_in = ~sr; vbr_in = vbr + 32'h400;
        seen = 0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            if (fetch_go) seen = 1;
        end
        req_valid = 1'b0;
        chk(seen, "R8 fetch strobe", 32'(seen), 32'h1);
        chk(fetch_addr == handler_of(haddr), "R8 handler address", fetch_addr, handler_of(haddr));
        chk(busy == 1'b1, "R1 busy during fetch", 32'(busy), 32'h1);
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy drops", 32'(busy), 32'h0);
        @(negedge clk);
        chk(sr_cnt == 1, "R11 single status strobe", 32'(sr_cnt), 32'h1);
        chk(sp_cnt == 1, "R7 single stack strobe", 32'(sp_cnt), 32'h1);
        chk(sp_seen == exp_sp, "R7 stack pointer", sp_seen, exp_sp);
        chk(exp_q.size() == 0, "R9 all accesses made", 32'(exp_q.size()), 32'h0);
        exp_q.delete();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", 32'(busy), 32'h0);
        chk(bus_req == 1'b0, "R9 reset bus idle", 32'(bus_req), 32'h0);
        chk(fetch_go == 1'b0, "R8 reset fetch", 32'(fetch_go), 32'h0);
        rst_n = 1'b1;
        // faults: lowest and highest type, varied alignment and latency
        run_exc(1'b0, 3'd0, 3'd0, 32'h0000_1000, 16'h0000, 32'h0000_8000, 32'h0000_0000, 8'h00, 0);
        run_exc(1'b0, 3'd7, 3'd0, 32'h1234_5678, 16'hA71F, 32'h0001_0003, 32'h0010_0000, 8'h00, 2);
        run_exc(1'b0, 3'd5, 3'd0, 32'hCAFE_0004, 16'h8000, 32'h0000_2002, 32'h0020_0400, 8'h00, 1);
        // interrupts: level and residues
        run_exc(1'b1, 3'd0, 3'd1, 32'h0000_4444, 16'h2000, 32'h0003_0001, 32'h0000_0000, 8'h40, 1);
        run_exc(1'b1, 3'd0, 3'd7, 32'hDEAD_BEE0, 16'h9300, 32'h0004_0002, 32'h0080_0000, 8'hFF, 3);
        run_exc(1'b1, 3'd6, 3'd4, 32'h0000_0010, 16'hFFFF, 32'h0000_0107, 32'h0000_1000, 8'h19, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule